// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable model of a single-port, word-wide synchronous SRAM with a pipelined late-write interface. A host can issue a read or a write on every enabled clock edge, in any mix and order, and never has to insert idle cycles when the bus changes direction. Each command owns one data slot on the shared bus, two edges after the command. A read drives its word during that slot. A write supplies its word at the end of that slot.

Write addresses and byte selects wait in internal pipeline registers until their data arrives. The data then waits one more register stage before it reaches the array. A read that targets a word still in flight returns the in-flight bytes merged over the array contents, so the host always sees a coherent memory. Four-word bursts are started by a load cycle and continued by advance cycles. The address sequence is either linear or interleaved within an aligned group of four words. A clock enable freezes the whole pipeline. An asynchronous output enable gates the bus drivers.

Top module: `lw_sram`

## Requirements
- R1: A read accepted at edge c (clk_en high) loads `dq_out` with the word and raises `dq_oe` at edge c+1. Both stay until edge c+2, where the host samples them.
- R2: A write accepted at edge c takes its word from `dq_in` at edge c+2. Only the lanes whose `byte_sel` bit is 1 are changed (lane i is bits 8i+7..8i). Every other lane keeps its old value.
- R3: A read whose address matches a write that is still in either pipeline stage returns that write's selected lanes merged over the array word. Where both stages match, the newer write wins lane by lane.
- R4: A load cycle (`adv_load`=0) starts a command only when `chip_sel` is all ones. Otherwise the cycle is a deselect, which neither writes nor drives the bus. An advance cycle that follows a deselect is also a deselect.
- R5: An advance cycle (`adv_load`=1) repeats the previous command type at the next burst address. `wr_en` and `chip_sel` are ignored on advance cycles.
- R6: With `burst_ilv`=0, the n-th word of a burst uses low address bits (start+n) mod 4. The upper address bits never change within a burst.
- R7: With `burst_ilv`=1, the n-th word of a burst uses low address bits start XOR n.
- R8: While `clk_en` is low, nothing is captured and every pipeline register, including `dq_out` and the drive state, holds its value.
- R9: `dq_oe` is low during the data slot of a write or a deselect.
- R10: `out_en`=0 forces `dq_oe` low at once, without waiting for a clock edge.
- R11: After reset, `dq_oe` is low, `dq_out` is zero and no command is pending.
- R12: Reads and writes issued back to back in any order complete with no wait states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Clock enable; low freezes the pipeline |
| adv_load | input | 1 | 0 = load a new command and address, 1 = advance the burst |
| wr_en | input | 1 | 1 = write, 0 = read (sampled on load cycles) |
| chip_sel | input | N_SEL (3) | Chip selects; all must be 1 to accept a load |
| byte_sel | input | 4 | Per-lane write selects |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W (8) | Word address |
| out_en | input | 1 | Asynchronous output enable |
| dq_in | input | 32 | Write data from the bus |
| dq_out | output | 32 | Read data toward the bus |
| dq_oe | output | 1 | Bus driver enable |

## Verification
The properties in the checker run on every edge. They cover the bus-drive rules (a read slot drives, any other slot stays quiet, and the output enable gates the drivers), the freeze under a low clock enable, the deselect on failed loads, and the linear burst step staying inside its aligned group. Data correctness can only be shown by the bench scenarios. These cover byte-lane merging, bypass from each pending write stage, interleaved sequences, the handling of a write delayed by a stall, and the release from reset.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;

  // Overlay the selected lanes of upd onto base.
  function automatic word_t lane_merge(word_t base, word_t upd, lane_mask_t sel);
    word_t res;
    res = base;
    for (int l = 0; l < LANES; l++) begin
      if (sel[l]) res[l*LANE_W +: LANE_W] = upd[l*LANE_W +: LANE_W];
    end
    return res;
  endfunction

  // Low address bits of burst beat cnt starting at start.
  function automatic logic [1:0] burst_low(logic [1:0] start, logic [1:0] cnt, logic ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/lw_sram_burst.sv
`timescale 1ns/1ps
module lw_sram_burst
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_SEL  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              adv_load,
  input  logic              wr_en,
  input  logic [N_SEL-1:0]  chip_sel,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  lane_mask_t        byte_sel,
  output logic              s1_vld,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output lane_mask_t        s1_bs
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0]   base_hi, base_hi_n;
  logic [1:0]        start_lo, start_lo_n;
  logic [1:0]        cnt, cnt_n;
  logic              vld_n, wr_n;
  logic [ADDR_W-1:0] addr_n;

  always_comb begin
    if (!adv_load) begin
      vld_n      = &chip_sel;
      wr_n       = wr_en;
      base_hi_n  = addr[ADDR_W-1:2];
      start_lo_n = addr[1:0];
      cnt_n      = 2'd0;
    end else begin
      vld_n      = s1_vld;
      wr_n       = s1_wr;
      base_hi_n  = base_hi;
      start_lo_n = start_lo;
      cnt_n      = cnt + 2'd1;
    end
    addr_n = {base_hi_n, burst_low(start_lo_n, cnt_n, burst_ilv)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_bs    <= '0;
      base_hi  <= '0;
      start_lo <= '0;
      cnt      <= '0;
    end else if (clk_en) begin
      s1_vld   <= vld_n;
      s1_wr    <= wr_n;
      s1_addr  <= addr_n;
      s1_bs    <= byte_sel;
      base_hi  <= base_hi_n;
      start_lo <= start_lo_n;
      cnt      <= cnt_n;
    end
  end
endmodule

// File: rtl/lw_sram_array.sv
`timescale 1ns/1ps
module lw_sram_array
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_word,
  input  lane_mask_t        wr_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output word_t             rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_go && wr_mask[g]) bank[wr_addr] <= wr_word[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = bank[rd_addr];
  end
endmodule

// File: rtl/lw_sram_bypass.sv
`timescale 1ns/1ps
module lw_sram_bypass
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  word_t             arr_word,
  input  logic              old_wr,
  input  logic [ADDR_W-1:0] old_addr,
  input  lane_mask_t        old_bs,
  input  word_t             old_data,
  input  logic              new_wr,
  input  logic [ADDR_W-1:0] new_addr,
  input  lane_mask_t        new_bs,
  input  word_t             new_data,
  output word_t             merged
);
  logic  old_hit, new_hit;
  word_t after_old;

  always_comb begin
    old_hit   = old_wr && (old_addr == rd_addr);
    new_hit   = new_wr && (new_addr == rd_addr);
    after_old = old_hit ? lane_merge(arr_word, old_data, old_bs) : arr_word;
    merged    = new_hit ? lane_merge(after_old, new_data, new_bs) : after_old;
  end
endmodule

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_SEL  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              adv_load,
  input  logic              wr_en,
  input  logic [N_SEL-1:0]  chip_sel,
  input  logic [LANES-1:0]  byte_sel,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic              out_en,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe
);
  // Reset synchronizer: asserts at once, releases after two edges.
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // Stage 1: command capture and burst address.
  logic              s1_vld, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  lane_mask_t        s1_bs;

  lw_sram_burst #(.ADDR_W(ADDR_W), .N_SEL(N_SEL)) u_burst (
    .clk      (clk),
    .rst_n    (rst_q),
    .clk_en   (clk_en),
    .adv_load (adv_load),
    .wr_en    (wr_en),
    .chip_sel (chip_sel),
    .burst_ilv(burst_ilv),
    .addr     (addr),
    .byte_sel (byte_sel),
    .s1_vld   (s1_vld),
    .s1_wr    (s1_wr),
    .s1_addr  (s1_addr),
    .s1_bs    (s1_bs)
  );

  // Stage 2: waiting for write data. Stage 3: data held until array write.
  logic              s2_vld, s2_wr, s3_vld, s3_wr;
  logic [ADDR_W-1:0] s2_addr, s3_addr;
  lane_mask_t        s2_bs, s3_bs;
  word_t             wdata_q, wdata_n;
  word_t             arr_word, merged, rd_q, rd_n;
  logic              rd_oe_q, rd_oe_n;
  logic              s1_rd, s2_wr_go, s3_wr_go;

  always_comb begin
    s1_rd    = s1_vld && !s1_wr;
    s2_wr_go = s2_vld && s2_wr;
    s3_wr_go = s3_vld && s3_wr;
    wdata_n  = s2_wr_go ? dq_in : wdata_q;
    rd_n     = s1_rd ? merged : rd_q;
    rd_oe_n  = s1_rd;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s2_vld  <= 1'b0;
      s2_wr   <= 1'b0;
      s2_addr <= '0;
      s2_bs   <= '0;
      s3_vld  <= 1'b0;
      s3_wr   <= 1'b0;
      s3_addr <= '0;
      s3_bs   <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
      rd_oe_q <= 1'b0;
    end else if (clk_en) begin
      s2_vld  <= s1_vld;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_bs   <= s1_bs;
      s3_vld  <= s2_vld;
      s3_wr   <= s2_wr;
      s3_addr <= s2_addr;
      s3_bs   <= s2_bs;
      wdata_q <= wdata_n;
      rd_q    <= rd_n;
      rd_oe_q <= rd_oe_n;
    end
  end

  lw_sram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk    (clk),
    .wr_go  (s3_wr_go && clk_en),
    .wr_addr(s3_addr),
    .wr_word(wdata_q),
    .wr_mask(s3_bs),
    .rd_addr(s1_addr),
    .rd_word(arr_word)
  );

  lw_sram_bypass #(.ADDR_W(ADDR_W)) u_bypass (
    .rd_addr (s1_addr),
    .arr_word(arr_word),
    .old_wr  (s3_wr_go),
    .old_addr(s3_addr),
    .old_bs  (s3_bs),
    .old_data(wdata_q),
    .new_wr  (s2_wr_go),
    .new_addr(s2_addr),
    .new_bs  (s2_bs),
    .new_data(dq_in),
    .merged  (merged)
  );

  assign dq_out = rd_q;
  assign dq_oe  = rd_oe_q && out_en;
endmodule

// File: rtl/lw_sram_chk.sv
`timescale 1ns/1ps
module lw_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int N_SEL  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              adv_load,
  input logic [N_SEL-1:0]  chip_sel,
  input logic              burst_ilv,
  input logic              out_en,
  input logic [31:0]       dq_out,
  input logic              dq_oe,
  input logic              s1_vld,
  input logic              s1_wr,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              s2_vld,
  input logic              s2_wr
);
  // R1: a read's data slot drives the bus when the output enable allows it
  a_r1_read_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && !s2_wr && out_en) |-> dq_oe);

  // R9: write and deselect slots leave the bus undriven
  a_r9_quiet_unless_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(s2_vld && !s2_wr) |-> !dq_oe);

  // R10: drivers never on while the output enable is low
  a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !dq_oe);

  // R8: a disabled edge changes nothing
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(dq_out) && $stable(s1_addr) && $stable(s1_vld) && $stable(s1_wr)));

  // R4: a load without every chip select is a deselect
  a_r4_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv_load && (chip_sel != {N_SEL{1'b1}})) |=> !s1_vld);

  // R5: an advance keeps command type and the aligned four-word group
  a_r5_burst_stays_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_load && s1_vld) |=>
      (s1_vld && (s1_wr == $past(s1_wr)) &&
       (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]))));

  // R6: linear advance steps the low bits by one, modulo four
  a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv_load && s1_vld && !burst_ilv) |=>
      (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1));
endmodule

bind lw_sram lw_sram_chk #(.ADDR_W(ADDR_W), .N_SEL(N_SEL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_en   (clk_en),
  .adv_load (adv_load),
  .chip_sel (chip_sel),
  .burst_ilv(burst_ilv),
  .out_en   (out_en),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe),
  .s1_vld   (s1_vld),
  .s1_wr    (s1_wr),
  .s1_addr  (s1_addr),
  .s2_vld   (s2_vld),
  .s2_wr    (s2_wr)
);

// File: tb/test_lw_sram.sv
`timescale 1ns/1ps
module test_lw_sram;
  logic        clk = 1'b0;
  logic        rst_n, clk_en, adv_load, wr_en, burst_ilv, out_en;
  logic [2:0]  chip_sel;
  logic [3:0]  byte_sel;
  logic [7:0]  addr;
  logic [31:0] dq_in, dq_out;
  logic        dq_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  lw_sram #(.ADDR_W(8), .N_SEL(3)) i_lw_sram (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_load(adv_load),
    .wr_en(wr_en), .chip_sel(chip_sel), .byte_sel(byte_sel),
    .burst_ilv(burst_ilv), .addr(addr), .out_en(out_en),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // ld: 1 = load, 0 = advance; wd: row supplies write data two rows later;
  // re: row expects read data d; rq: requirement number reported.
  typedef struct packed {
    logic        ld;
    logic        wr;
    logic [2:0]  cs;
    logic [3:0]  bs;
    logic        ilv;
    logic [7:0]  a;
    logic [31:0] d;
    logic        wd;
    logic        re;
    logic [3:0]  rq;
  } row_t;

  localparam int N = 30;
  localparam row_t TBL [N] = '{
    '{1'b1,1'b1,3'b111,4'hF,1'b0,8'h10,32'h11111111,1'b1,1'b0,4'd9},  // R2 write
    '{1'b1,1'b0,3'b111,4'hF,1'b0,8'h10,32'h11111111,1'b0,1'b1,4'd3},  // R3 newer-stage bypass
    '{1'b1,1'b1,3'b111,4'hF,1'b0,8'h20,32'h22222222,1'b1,1'b0,4'd9},
    '{1'b1,1'b1,3'b111,4'h3,1'b0,8'h20,32'hAAAAAAAA,1'b1,1'b0,4'd9},
    '{1'b1,1'b0,3'b111,4'hF,1'b0,8'h20,32'h2222AAAA,1'b0,1'b1,4'd3},  // R3 both stages
    '{1'b1,1'b0,3'b111,4'hF,1'b0,8'h10,32'h11111111,1'b0,1'b1,4'd1},  // R1 from array
    '{1'b1,1'b0,3'b011,4'hF,1'b0,8'h10,32'h00000000,1'b0,1'b0,4'd4},  // R4 deselect
    '{1'b0,1'b1,3'b111,4'hF,1'b0,8'h00,32'h00000000,1'b0,1'b0,4'd4},  // R4 advance stays idle
    '{1'b1,1'b1,3'b111,4'hF,1'b0,8'h41,32'h00000041,1'b1,1'b0,4'd12},
    '{1'b0,1'b0,3'b000,4'hF,1'b0,8'h00,32'h00000042,1'b1,1'b0,4'd5},  // R5 advance write
    '{1'b0,1'b0,3'b000,4'hF,1'b0,8'h00,32'h00000043,1'b1,1'b0,4'd5},
    '{1'b0,1'b0,3'b000,4'hF,1'b0,8'h00,32'h00000040,1'b1,1'b0,4'd5},
    '{1'b1,1'b0,3'b111,4'hF,1'b0,8'h41,32'h00000041,1'b0,1'b1,4'd12}, // R12 write->read
    '{1'b0,1'b1,3'b000,4'hF,1'b0,8'h00,32'h00000042,1'b0,1'b1,4'd6},  // R6 linear
    '{1'b0,1'b1,3'b000,4'hF,1'b0,8'h00,32'h00000043,1'b0,1'b1,4'd6},
    '{1'b0,1'b1,3'b000,4'hF,1'b0,8'h00,32'h00000040,1'b0,1'b1,4'd6},  // R6 wrap
    '{1'b1,1'b0,3'b111,4'hF,1'b1,8'h41,32'h00000041,1'b0,1'b1,4'd7},  // R7 interleaved
    '{1'b0,1'b1,3'b000,4'hF,1'b1,8'h00,32'h00000040,1'b0,1'b1,4'd7},
    '{1'b0,1'b1,3'b000,4'hF,1'b1,8'h00,32'h00000043,1'b0,1'b1,4'd7},
    '{1'b0,1'b1,3'b000,4'hF,1'b1,8'h00,32'h00000042,1'b0,1'b1,4'd7},
    '{1'b1,1'b1,3'b111,4'hF,1'b0,8'h50,32'h55555555,1'b1,1'b0,4'd9},
    '{1'b1,1'b1,3'b111,4'hF,1'b0,8'h60,32'h66666666,1'b1,1'b0,4'd12},
    '{1'b1,1'b0,3'b111,4'hF,1'b0,8'h50,32'h55555555,1'b0,1'b1,4'd3},  // R3 older stage only
    '{1'b1,1'b0,3'b111,4'hF,1'b0,8'h60,32'h66666666,1'b0,1'b1,4'd3},
    '{1'b1,1'b1,3'b111,4'h8,1'b0,8'h50,32'h77FFFFFF,1'b1,1'b0,4'd2},  // R2 lane 3 only
    '{1'b1,1'b0,3'b110,4'hF,1'b0,8'h00,32'h00000000,1'b0,1'b0,4'd9},  // R9 deselect slot
    '{1'b1,1'b0,3'b111,4'hF,1'b0,8'h50,32'h77555555,1'b0,1'b1,4'd2},  // R2 lane merge
    '{1'b1,1'b1,3'b111,4'hF,1'b0,8'h70,32'h12345678,1'b1,1'b0,4'd12},
    '{1'b1,1'b0,3'b111,4'hF,1'b0,8'h70,32'h12345678,1'b0,1'b1,4'd12}, // R12 turnaround
    '{1'b1,1'b0,3'b000,4'hF,1'b0,8'h00,32'h00000000,1'b0,1'b0,4'd9}
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (ok !== 1'b1) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_cmd();
    adv_load = 1'b0; wr_en = 1'b0; chip_sel = 3'b000; byte_sel = 4'h0;
    addr = 8'h00; burst_ilv = 1'b0;
  endtask

  task automatic load_cmd(input logic w, input logic [7:0] a);
    adv_load = 1'b0; wr_en = w; chip_sel = 3'b111; byte_sel = 4'hF;
    addr = a; burst_ilv = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; clk_en = 1'b1; out_en = 1'b1; dq_in = '0;
    idle_cmd();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(dq_oe == 1'b0, "R11 dq_oe after reset", {31'd0, dq_oe}, 32'd0);
    check(dq_out == 32'd0, "R11 dq_out after reset", dq_out, 32'd0);

    // Vector table: one row per enabled edge.
    for (int i = 0; i < N + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        if (TBL[i-2].re) begin
          check(dq_oe == 1'b1, $sformatf("R%0d row %0d drive", TBL[i-2].rq, i-2), {31'd0, dq_oe}, 32'd1);
          check(dq_out == TBL[i-2].d, $sformatf("R%0d row %0d data", TBL[i-2].rq, i-2), dq_out, TBL[i-2].d);
        end else begin
          check(dq_oe == 1'b0, $sformatf("R%0d row %0d quiet", TBL[i-2].rq, i-2), {31'd0, dq_oe}, 32'd0);
        end
      end
      if (i < N) begin
        adv_load  = ~TBL[i].ld;
        wr_en     = TBL[i].wr;
        chip_sel  = TBL[i].cs;
        byte_sel  = TBL[i].bs;
        burst_ilv = TBL[i].ilv;
        addr      = TBL[i].a;
      end else begin
        idle_cmd();
      end
      dq_in = (i >= 2 && TBL[i-2].wd) ? TBL[i-2].d : 32'hDEADBEEF;
    end

    // R8: stall between read command and its output edge
    @(negedge clk);
    load_cmd(1'b0, 8'h10);
    @(negedge clk);
    clk_en = 1'b0;
    idle_cmd();
    repeat (3) @(negedge clk);
    check(dq_oe == 1'b0, "R8 output not advanced while stalled", {31'd0, dq_oe}, 32'd0);
    clk_en = 1'b1;
    @(negedge clk);
    check(dq_oe == 1'b1, "R8 read resumes drive", {31'd0, dq_oe}, 32'd1);
    check(dq_out == 32'h11111111, "R8 read data after stall", dq_out, 32'h11111111);
    clk_en = 1'b0;
    repeat (2) @(negedge clk);
    check(dq_out == 32'h11111111 && dq_oe == 1'b1, "R8 output held", dq_out, 32'h11111111);
    // R10: asynchronous gating, no clock edge in between
    out_en = 1'b0;
    #2;
    check(dq_oe == 1'b0, "R10 drivers off without edge", {31'd0, dq_oe}, 32'd0);
    out_en = 1'b1;
    #2;
    check(dq_oe == 1'b1, "R10 drivers back on", {31'd0, dq_oe}, 32'd1);
    clk_en = 1'b1;
    @(negedge clk);
    check(dq_oe == 1'b0, "R9 deselect slot quiet", {31'd0, dq_oe}, 32'd0);

    // R8: write whose data slot is stretched by a stall
    load_cmd(1'b1, 8'h90);
    @(negedge clk);
    idle_cmd();
    dq_in = 32'h0BAD0BAD;
    @(negedge clk);
    clk_en = 1'b0;
    dq_in  = 32'hBADBADBA;
    repeat (2) @(negedge clk);
    clk_en = 1'b1;
    dq_in  = 32'hCAFEF00D;
    @(negedge clk);
    dq_in = 32'h0;
    load_cmd(1'b0, 8'h90);
    @(negedge clk);
    idle_cmd();
    @(negedge clk);
    check(dq_out == 32'hCAFEF00D, "R8 write data taken at second enabled edge", dq_out, 32'hCAFEF00D);

    finish_run();
  end
endmodule